// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that copies data by following a chain of descriptors kept in memory. Each descriptor is four 32-bit words at a 16-byte aligned address. In order they are: the link to the next descriptor, the source address, the target address and a command word. Software loads the address of the first descriptor, sets the run bit, and the channel then works through the chain on its own until it reaches a link marked as the last one.

A single memory master port carries both the descriptor fetches and the data beats. Every access is a request held until the memory answers with ready, and an answer may also flag an error. Data reaches the port right-justified, with a size code. For each descriptor the command word sets the byte count, the beat width, whether each address advances, whether a peripheral request paces the transfer in bursts, and whether the start and end of that descriptor raise status. Status bits drive a level interrupt and are cleared by writing ones to them.

Top module: `dma_link_chan`

## Requirements
- R1: After reset the control word (select 0) reads 0x0000_0008, meaning stopped and idle. Selects 1 to 4 read zero and irq is low.
- R2: Register selects are 0 control/status, 1 next-descriptor link, 2 source, 3 target and 4 command. While the channel is stopped, selects 1 to 4 take the written value. While it is busy, writes to them are ignored.
- R3: Writing control bit 31 (run) as 1 while stopped makes the channel read the four words at {link[31:4],4'h0} in the order link, source, target, command, placing each in its register. No data access happens before all four words are loaded.
- R4: Command bits 15:14 set the beat width: 1 is 1 byte, 2 is 2 bytes, 3 or 0 is 4 bytes. When fewer bytes remain than the width, single-byte beats finish the count. Each beat reads from the source and then writes the same bytes to the target. mem_size is 0, 1 or 2 for 1, 2 or 4 bytes.
- R5: Command bit 31 advances the source address and bit 30 advances the target address, each by the beat size. Command bits 12:0 hold the remaining byte count and count down to zero in the command register.
- R6: When the byte count reaches zero, the channel stops if bit 0 of the link register is set: run clears and control bit 3 sets. Otherwise it fetches the descriptor at the link address. A descriptor with a count of zero moves no data.
- R7: Status bit 1 (start) sets when a loaded descriptor has command bit 22 set. Status bit 2 (end) sets only when a completing descriptor has command bit 21 set.
- R8: Writing a 1 to any of control bits 2:0 clears that status bit, and a write of 0 leaves it unchanged. irq is high while any of status bits 2:0 is set.
- R9: A memory answer with mem_err during a fetch or a data beat sets status bit 0, clears run and stops the channel, with no further memory access.
- R10: When command bit 29 or bit 28 is set, the channel waits for dreq before each burst. Command bits 17:16 give the burst size (1 is 8 bytes, 2 is 16 bytes, 3 is 32 bytes, 0 is one beat). Control bit 8 reads 1 while the channel is busy with such a descriptor and dreq is high.
- R11: Writing run as 0 while busy stops the channel once the memory access in progress is done, without end status.
- R12: Once mem_req is raised, it stays high with a stable address and direction until mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_size | output | 2 | Access size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes |
| mem_ready | input | 1 | Access complete |
| mem_err | input | 1 | Error on the completing access |
| mem_rdata | input | 32 | Read data, right-justified |
| dreq | input | 1 | Peripheral request for flow-controlled bursts |
| irq | output | 1 | Level interrupt, OR of status bits |

## Verification
The assertions assume that mem_ready arrives only as a one-cycle answer to a pending mem_req, and that mem_err is meaningful only alongside mem_ready. The bench memory answers after a random delay and always drops ready in the following cycle. Error answers come only for addresses outside the modelled 4 KB, which keeps error injection limited to the directed cases that aim at such addresses. Random chains keep sources, targets and descriptors in separate regions, so the bench's byte-copy model is never affected by overlap. The dreq input is either toggled at random or held and pulsed in directed steps.

// File: rtl/dma_link_chan.sv
module dma_link_chan (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [1:0]  mem_size,
  input  logic        mem_ready,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  input  logic        dreq,
  output logic        irq
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_WAIT, S_RD, S_WR, S_END} st_t;

  st_t         st;
  logic        run;
  logic [2:0]  sts, sts_set;
  logic [31:0] nxt, src, tgt, cmd, dbuf;
  logic [27:0] dbase;
  logic [1:0]  widx;
  logic [5:0]  bleft;
  logic [2:0]  wbytes;
  logic [5:0]  bbytes;

  wire idle    = (st == S_IDLE);
  wire quiet   = idle & ~run;
  wire flow    = cmd[29] | cmd[28];
  wire csr_wr  = reg_we && (reg_sel == 3'd0);
  wire [12:0] len     = cmd[12:0];
  wire [2:0]  bsz     = (len >= {10'b0, wbytes}) ? wbytes : 3'd1;
  wire [12:0] len_nx  = len - {10'b0, bsz};
  wire [5:0]  bleft_nx = (bleft > {3'b0, bsz}) ? bleft - {3'b0, bsz} : 6'd0;
  wire        acc_err = mem_req & mem_ready & mem_err;
  wire        req_pend = ~idle & flow & dreq;

  always_comb begin
    case (cmd[15:14])
      2'd1:    wbytes = 3'd1;
      2'd2:    wbytes = 3'd2;
      default: wbytes = 3'd4;
    endcase
    case (cmd[17:16])
      2'd1:    bbytes = 6'd8;
      2'd2:    bbytes = 6'd16;
      2'd3:    bbytes = 6'd32;
      default: bbytes = {3'b0, wbytes};
    endcase
  end

  assign mem_req   = (st == S_FETCH) || (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_FETCH) ? {dbase, widx, 2'b00} : (st == S_WR) ? tgt : src;
  assign mem_size  = (st == S_FETCH || bsz == 3'd4) ? 2'd2 : (bsz == 3'd2) ? 2'd1 : 2'd0;
  assign mem_wdata = dbuf;
  assign irq       = |sts;

  assign sts_set[0] = acc_err;
  assign sts_set[1] = (st == S_CHECK) & run & cmd[22];
  assign sts_set[2] = (st == S_END) & cmd[21];

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = {run, 22'b0, req_pend, 4'b0, quiet, sts};
      3'd1:    reg_rdata = nxt;
      3'd2:    reg_rdata = src;
      3'd3:    reg_rdata = tgt;
      3'd4:    reg_rdata = cmd;
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; run <= 1'b0; sts <= 3'b0;
      nxt <= '0; src <= '0; tgt <= '0; cmd <= '0; dbuf <= '0;
      dbase <= '0; widx <= '0; bleft <= '0;
    end else begin
      sts <= (sts & ~(csr_wr ? reg_wdata[2:0] : 3'b0)) | sts_set;
      if (csr_wr) begin
        if (idle) run <= reg_wdata[31];
        else if (!reg_wdata[31]) run <= 1'b0;
      end
      if (quiet && reg_we) begin
        case (reg_sel)
          3'd1: nxt <= reg_wdata;
          3'd2: src <= reg_wdata;
          3'd3: tgt <= reg_wdata;
          3'd4: cmd <= reg_wdata;
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (run) begin
          st <= S_FETCH; dbase <= nxt[31:4]; widx <= 2'd0;
        end
        S_FETCH: if (mem_ready) begin
          if (mem_err) begin
            run <= 1'b0; st <= S_IDLE;
          end else begin
            case (widx)
              2'd0: nxt <= mem_rdata;
              2'd1: src <= mem_rdata;
              2'd2: tgt <= mem_rdata;
              default: cmd <= mem_rdata;
            endcase
            widx <= widx + 2'd1;
            if (!run) st <= S_IDLE;
            else if (widx == 2'd3) st <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (!run) st <= S_IDLE;
          else if (len == 13'd0) st <= S_END;
          else if (flow) st <= S_WAIT;
          else st <= S_RD;
        end
        S_WAIT: begin
          if (!run) st <= S_IDLE;
          else if (dreq) begin
            bleft <= bbytes; st <= S_RD;
          end
        end
        S_RD: if (mem_ready) begin
          if (mem_err) begin
            run <= 1'b0; st <= S_IDLE;
          end else begin
            dbuf <= mem_rdata; st <= S_WR;
          end
        end
        S_WR: if (mem_ready) begin
          if (mem_err) begin
            run <= 1'b0; st <= S_IDLE;
          end else begin
            if (cmd[31]) src <= src + {29'b0, bsz};
            if (cmd[30]) tgt <= tgt + {29'b0, bsz};
            cmd[12:0] <= len_nx;
            bleft <= bleft_nx;
            if (len_nx == 13'd0) st <= S_END;
            else if (!run) st <= S_IDLE;
            else if (flow && bleft_nx == 6'd0) st <= S_WAIT;
            else st <= S_RD;
          end
        end
        S_END: begin
          if (nxt[0] || !run) begin
            run <= 1'b0; st <= S_IDLE;
          end else begin
            st <= S_FETCH; dbase <= nxt[31:4]; widx <= 2'd0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r12_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r9_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && mem_err) |=> (!mem_req && !run && sts[0]));

  a_r10_wait_for_dreq: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !dreq) |=> !mem_req);

  a_r5_count_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && mem_ready && !mem_err) |=> (cmd[12:0] < $past(cmd[12:0])));

  a_r7_end_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> cmd[21]);

  a_r6_stop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_END && nxt[0]) |=> (idle && !run));
endmodule

// File: tb/sim_dma_link_chan.sv
`timescale 1ns/1ps
module sim_dma_link_chan;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ready = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        dreq = 1'b0, irq;
  logic        dreq_rand = 1'b0;

  logic [7:0]  mem [0:4095];
  logic [7:0]  expm [0:4095];
  logic [31:0] alog [0:63];
  logic        wlog [0:63];
  int          nlog = 0, nwr = 0;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  dma_link_chan u0 (.clk, .rst_n, .reg_we, .reg_sel, .reg_wdata, .reg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_size, .mem_ready, .mem_err,
    .mem_rdata, .dreq, .irq);

  initial begin : mem_model
    int lat, nb;
    logic bad;
    lat = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0; mem_err = 1'b0;
      end else if (mem_req) begin
        if (lat > 0) lat--;
        else begin
          lat = $urandom % 3;
          nb = (mem_size == 2'd0) ? 1 : (mem_size == 2'd1) ? 2 : 4;
          bad = (mem_addr > 32'd4096 - nb);
          if (nlog < 64) begin alog[nlog] = mem_addr; wlog[nlog] = mem_we; nlog++; end
          if (!bad) begin
            if (mem_we) begin
              for (int k = 0; k < nb; k++) mem[mem_addr + k] = mem_wdata[8*k +: 8];
              nwr++;
            end else begin
              mem_rdata = '0;
              for (int k = 0; k < nb; k++) mem_rdata[8*k +: 8] = mem[mem_addr + k];
            end
          end
          mem_err = bad;
          mem_ready = 1'b1;
        end
      end
    end
  end

  initial begin : dreq_noise
    forever begin
      @(negedge clk);
      if (dreq_rand) dreq = $urandom % 2;
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b0; reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_stop(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd0, v);
      if (v[3] && !v[31]) return;
    end
    chk({tag, " stop timeout"}, 32'd0, 32'd1);
  endtask

  task automatic put(input int a, input logic [31:0] w);
    for (int k = 0; k < 4; k++) begin
      mem[a + k] = w[8*k +: 8];
      expm[a + k] = w[8*k +: 8];
    end
  endtask

  function automatic logic [31:0] mkcmd(bit is, bit it, bit fl, bit se, bit ee,
                                        int b, int w, int len);
    return (32'(is) << 31) | (32'(it) << 30) | (32'(fl) << 29) | (32'(se) << 22) |
           (32'(ee) << 21) | (32'(b) << 16) | (32'(w) << 14) | 32'(len);
  endfunction

  task automatic model_copy(inout logic [31:0] s, inout logic [31:0] t, input logic [31:0] c);
    int len, w, b;
    logic [7:0] tmp [4];
    len = c[12:0];
    w = (c[15:14] == 2'd1) ? 1 : (c[15:14] == 2'd2) ? 2 : 4;
    while (len > 0) begin
      b = (len >= w) ? w : 1;
      for (int k = 0; k < b; k++) tmp[k] = expm[s + k];
      for (int k = 0; k < b; k++) expm[t + k] = tmp[k];
      if (c[31]) s = s + b;
      if (c[30]) t = t + b;
      len -= b;
    end
  endtask

  task automatic cmp_mem(input string tag);
    int mis = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== expm[i]) mis++;
    chk(tag, mis, 0);
  endtask

  task automatic start_at(input logic [31:0] base);
    nlog = 0; nwr = 0;
    wr(3'd1, base);
    wr(3'd0, 32'h8000_0000);
  endtask

  initial begin
    logic [31:0] v, s, t, c, lastn;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) begin mem[i] = 8'($urandom); expm[i] = mem[i]; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 csr", v, 32'h8);
    rd(3'd4, v); chk("R1 cmd", v, 32'h0);
    chk("R1 irq", irq, 1'b0);

    // R2 register access while stopped
    wr(3'd2, 32'h1234_5678); rd(3'd2, v); chk("R2 src rw", v, 32'h1234_5678);
    wr(3'd3, 32'h0000_0abc); rd(3'd3, v); chk("R2 tgt rw", v, 32'h0000_0abc);

    // R3 R4 R5: fetch order, width 4 with remainder of 3 single bytes
    put(32'h40, 32'h0000_0001); put(32'h44, 32'h500); put(32'h48, 32'h900);
    c = mkcmd(1, 1, 0, 0, 0, 0, 3, 7); put(32'h4c, c);
    s = 32'h500; t = 32'h900; model_copy(s, t, c);
    start_at(32'h40); wait_stop("R3");
    chk("R3 fetch0", alog[0], 32'h40); chk("R3 fetch3", alog[3], 32'h4c);
    chk("R3 first data read at src", alog[4], 32'h500);
    chk("R4 beat count", nwr, 4);
    cmp_mem("R4 copied bytes");
    rd(3'd2, v); chk("R5 src advanced", v, s);
    rd(3'd4, v); chk("R5 count zero", v[12:0], 13'd0);
    rd(3'd1, v); chk("R6 link kept", v, 32'h1);

    // R6 R7: zero-length link then a real one, end enabled on both
    put(32'h60, 32'h70); put(32'h64, 32'h600); put(32'h68, 32'ha00);
    put(32'h6c, mkcmd(1, 1, 0, 0, 1, 0, 3, 0));
    put(32'h70, 32'h1); put(32'h74, 32'h610); put(32'h78, 32'ha10);
    c = mkcmd(1, 1, 0, 1, 1, 0, 2, 4); put(32'h7c, c);
    s = 32'h610; t = 32'ha10; model_copy(s, t, c);
    start_at(32'h60); wait_stop("R6");
    chk("R6 zero length moves nothing", nwr, 2);
    cmp_mem("R6 chained copy");
    rd(3'd0, v); chk("R7 start and end status", v[2:0], 3'b110);
    chk("R8 irq high", irq, 1'b1);
    wr(3'd0, 32'h2); rd(3'd0, v); chk("R8 w1c start only", v[2:0], 3'b100);
    wr(3'd0, 32'h4); rd(3'd0, v); chk("R8 w1c end", v[2:0], 3'b000);
    chk("R8 irq low", irq, 1'b0);

    // R7 end not set when bit 21 clear
    put(32'h80, 32'h1); put(32'h84, 32'h620); put(32'h88, 32'ha20);
    c = mkcmd(1, 1, 0, 0, 0, 0, 1, 3); put(32'h8c, c);
    s = 32'h620; t = 32'ha20; model_copy(s, t, c);
    start_at(32'h80); wait_stop("R7");
    rd(3'd0, v); chk("R7 no end without enable", v[2:0], 3'b000);

    // R9 bus error on a data read
    put(32'h90, 32'h1); put(32'h94, 32'h2000_0000); put(32'h98, 32'ha40);
    put(32'h9c, mkcmd(1, 1, 0, 0, 1, 0, 3, 4));
    start_at(32'h90); wait_stop("R9");
    rd(3'd0, v); chk("R9 data error status", v, 32'h9);
    chk("R9 no write after error", nwr, 0);
    wr(3'd0, 32'h1);
    // R9 bus error on a descriptor fetch
    start_at(32'h0001_0000); wait_stop("R9f");
    rd(3'd0, v); chk("R9 fetch error status", v, 32'h9);
    chk("R9 one access only", nlog, 1);
    wr(3'd0, 32'h1);

    // R10 R2: flow control, width 1, 8-byte bursts, 16 bytes
    dreq = 1'b0;
    put(32'ha0, 32'h1); put(32'ha4, 32'h640); put(32'ha8, 32'ha60);
    c = mkcmd(1, 1, 1, 0, 1, 1, 1, 16); put(32'hac, c);
    s = 32'h640; t = 32'ha60; model_copy(s, t, c);
    start_at(32'ha0);
    repeat (30) @(negedge clk);
    rd(3'd4, v); chk("R10 no beat without dreq", v[12:0], 13'd16);
    rd(3'd0, v); chk("R10 pending low", v[8], 1'b0);
    wr(3'd2, 32'hdead_0000); rd(3'd2, v); chk("R2 write ignored while busy", v, 32'h640);
    @(negedge clk); dreq = 1'b1; reg_sel = 3'd0; #1 v = reg_rdata;
    chk("R10 pending high", v[8], 1'b1);
    @(negedge clk); dreq = 1'b0;
    repeat (120) @(negedge clk);
    chk("R10 one burst of 8", nwr, 8);
    rd(3'd4, v); chk("R10 half left", v[12:0], 13'd8);
    dreq = 1'b1; wait_stop("R10"); dreq = 1'b0;
    chk("R10 all beats", nwr, 16);
    cmp_mem("R10 paced copy");
    wr(3'd0, 32'h7);

    // R11 abort while waiting for dreq
    put(32'hb0, 32'h1); put(32'hb4, 32'h660); put(32'hb8, 32'ha80);
    put(32'hbc, mkcmd(1, 1, 1, 0, 1, 0, 3, 8));
    start_at(32'hb0);
    repeat (20) @(negedge clk);
    wr(3'd0, 32'h0);
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R11 aborted and stopped", v, 32'h8);
    rd(3'd4, v); chk("R11 nothing moved", v[12:0], 13'd8);

    // Random chains
    dreq_rand = 1'b1;
    for (int it = 0; it < 24; it++) begin
      int n, off;
      logic es, ee;
      n = 1 + $urandom % 3; off = (it % 4) * 32'h40;
      es = 0; ee = 0;
      for (int i = 32'h400; i < 32'h800; i++) begin mem[i] = 8'($urandom); expm[i] = mem[i]; end
      for (int j = 0; j < n; j++) begin
        logic [31:0] a, lk;
        a = off + 16 * j;
        lk = (j == n - 1) ? (($urandom & 32'hFFFF_FFF0) | 32'h1) : (off + 16 * (j + 1));
        s = 32'h400 + $urandom % 32'h300; t = 32'h800 + 32'h100 * j + $urandom % 32'h40;
        c = mkcmd($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                  $urandom % 4, $urandom % 4, $urandom % 48);
        es |= c[22]; ee |= c[21];
        put(a, lk); put(a + 4, s); put(a + 8, t); put(a + 12, c);
        model_copy(s, t, c);
        lastn = lk;
      end
      wr(3'd0, 32'h7);
      start_at(off);
      wait_stop("random");
      cmp_mem("R4 R5 random chain memory");
      rd(3'd2, v); chk("R5 random src end", v, s);
      rd(3'd3, v); chk("R5 random tgt end", v, t);
      rd(3'd4, v); chk("R5 random cmd end", v, c & 32'hFFFF_E000);
      rd(3'd1, v); chk("R6 random link end", v, lastn);
      rd(3'd0, v); chk("R7 random status", v[2:0], {ee, es, 1'b0});
      chk("R8 random irq", irq, ee | es);
    end
    dreq_rand = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule